// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the 32-bit program counter and works out, one instruction at a time, where fetch continues next. It takes each fetched instruction word on a valid/ready input and applies one of five flow choices. The first is plain sequential advance by one word. The second is a conditional branch with a signed 16-bit byte offset, taken when the external comparison says so. The third is an absolute jump built from a 26-bit word address. The fourth is a jump to a full 32-bit register value. The fifth is a forced redirect to a fixed exception vector. For call instructions it also presents the return address to the register file on the same cycle the call is accepted.

Instructions are 32 bits wide and word aligned. The opcode sits in bits 5..0 of the word and is brought out as a field. The branch offset is taken from bits 21..6 and the jump word address from bits 31..6. Instruction decode, the branch comparison and the register file are outside the block, so each flow choice arrives as a plain control pin. Back-pressure follows one rule: `instr_ready` is low exactly while `stall` is high. An instruction counts as accepted only in a cycle where `instr_valid` and `instr_ready` are both high. The upstream stage must hold the word and its control pins until that happens.

Top module: `npc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, `pc_q` equals the parameter RESET_PC (default 0x0000_1000) until the first update.
- R2: An accepted instruction with no exception, no register jump, no absolute jump and `br_taken` low makes `pc_q` equal to the old `pc_q` + 4 one clock later.
- R3: An accepted instruction with `br_taken` high, and no higher-priority choice, loads old `pc_q` + 4 + sign-extended `instr[21:6]`. The offset is in bytes.
- R4: An accepted instruction with `is_jump` high, and no higher-priority choice, loads {old `pc_q`[31:28], `instr[31:6]`, 2'b00}.
- R5: An accepted instruction with `is_jreg` high and no exception loads the full 32-bit `rs_val` unchanged, including its low two bits.
- R6: With `stall` low, `exc_req` high loads the parameter EXC_VECTOR (default 0x0000_0020) on the next edge, whether or not `instr_valid` is high.
- R7: When several choices are raised together, the priority is exception, then register jump, then absolute jump, then taken branch, then sequential advance.
- R8: While `stall` is high, `instr_ready` is low and `pc_q` keeps its value, even with `exc_req` or any flow pin high.
- R9: With `stall` low, `instr_valid` low and `exc_req` low, `pc_q` keeps its value.
- R10: `ret_addr` always equals `pc_q` + 4. `ret_valid` is high exactly when an instruction with `is_call` high is accepted.
- R11: `opcode` always equals `instr[5:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze the program counter and refuse input |
| instr_valid | input | 1 | Instruction word and flow pins are present |
| instr_ready | output | 1 | Block can accept an instruction this cycle |
| instr | input | 32 | Fetched instruction word |
| br_taken | input | 1 | Instruction is a branch whose condition holds |
| is_jump | input | 1 | Instruction is an absolute 26-bit jump |
| is_jreg | input | 1 | Instruction jumps to a register value |
| is_call | input | 1 | Instruction saves a return address |
| rs_val | input | 32 | Source register value for register jumps |
| exc_req | input | 1 | Redirect to the exception vector |
| pc_q | output | 32 | Current program counter |
| opcode | output | 6 | Opcode field of `instr` |
| ret_addr | output | 32 | Return address for calls |
| ret_valid | output | 1 | Write strobe for the return address |

## Verification
All internal state sits in the one program-counter register, so any wrong selection or wrong target shows at `pc_q` on the edge right after the instruction is accepted. It also shifts `ret_addr` by the same amount at once. A wrong priority between choices shows only when several flow pins are raised in the same accepted cycle, so those combinations are driven on purpose. A stall or idle fault shows as `pc_q` moving when it should hold. The bench compares every cycle against a model so that such a fault shows up within one clock.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    SEL_SEQ  = 3'd0,
    SEL_BR   = 3'd1,
    SEL_JMP  = 3'd2,
    SEL_REG  = 3'd3,
    SEL_EXC  = 3'd4
  } npc_sel_e;
endpackage

// File: rtl/npc_fields.sv
module npc_fields #(
  parameter int IW    = 32,
  parameter int OP_W  = 6,
  parameter int BR_W  = 16,
  parameter int JMP_W = 26
) (
  input  logic [IW-1:0]    instr,
  output logic [OP_W-1:0]  opcode,
  output logic [IW-1:0]    br_off,
  output logic [JMP_W-1:0] jmp_word
);
  localparam int BR_LO  = OP_W;
  localparam int BR_HI  = OP_W + BR_W - 1;
  localparam int JMP_LO = OP_W;
  localparam int JMP_HI = OP_W + JMP_W - 1;

  logic [BR_W-1:0] br_raw;

  assign opcode   = instr[OP_W-1:0];
  assign br_raw   = instr[BR_HI:BR_LO];
  // sign extension of the byte offset
  assign br_off   = {{(IW-BR_W){br_raw[BR_W-1]}}, br_raw};
  assign jmp_word = instr[JMP_HI:JMP_LO];
endmodule

// File: rtl/npc_target.sv
module npc_target #(
  parameter int AW    = 32,
  parameter int JMP_W = 26
) (
  input  logic [AW-1:0]    pc,
  input  logic [AW-1:0]    br_off,
  input  logic [JMP_W-1:0] jmp_word,
  output logic [AW-1:0]    seq_tgt,
  output logic [AW-1:0]    br_tgt,
  output logic [AW-1:0]    jmp_tgt
);
  localparam int KEEP_W = AW - JMP_W - 2;

  assign seq_tgt = pc + AW'(4);
  assign br_tgt  = seq_tgt + br_off;
  // upper bits come from the current PC, not the incremented one
  assign jmp_tgt = {pc[AW-1 -: KEEP_W], jmp_word, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
(
  input  logic     exc_req,
  input  logic     accept,
  input  logic     is_jreg,
  input  logic     is_jump,
  input  logic     br_taken,
  output npc_sel_e sel
);
  always_comb begin
    if (exc_req)                   sel = SEL_EXC;
    else if (accept && is_jreg)    sel = SEL_REG;
    else if (accept && is_jump)    sel = SEL_JMP;
    else if (accept && br_taken)   sel = SEL_BR;
    else                           sel = SEL_SEQ;
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          AW         = 32,
  parameter int          OP_W       = 6,
  parameter int          BR_W       = 16,
  parameter int          JMP_W      = 26,
  parameter logic [31:0] RESET_PC   = 32'h0000_1000,
  parameter logic [31:0] EXC_VECTOR = 32'h0000_0020
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stall,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [AW-1:0]   instr,
  input  logic            br_taken,
  input  logic            is_jump,
  input  logic            is_jreg,
  input  logic            is_call,
  input  logic [AW-1:0]   rs_val,
  input  logic            exc_req,
  output logic [AW-1:0]   pc_q,
  output logic [OP_W-1:0] opcode,
  output logic [AW-1:0]   ret_addr,
  output logic            ret_valid
);
  logic [AW-1:0]    br_off;
  logic [JMP_W-1:0] jmp_word;
  logic [AW-1:0]    seq_tgt, br_tgt, jmp_tgt;
  logic [AW-1:0]    pc_d;
  logic             accept, update;
  npc_sel_e         sel;

  assign instr_ready = !stall;
  assign accept      = instr_valid && instr_ready;
  assign update      = !stall && (accept || exc_req);

  npc_fields #(.IW(AW), .OP_W(OP_W), .BR_W(BR_W), .JMP_W(JMP_W)) u_fields (
    .instr(instr), .opcode(opcode), .br_off(br_off), .jmp_word(jmp_word)
  );

  npc_target #(.AW(AW), .JMP_W(JMP_W)) u_target (
    .pc(pc_q), .br_off(br_off), .jmp_word(jmp_word),
    .seq_tgt(seq_tgt), .br_tgt(br_tgt), .jmp_tgt(jmp_tgt)
  );

  npc_select u_select (
    .exc_req(exc_req), .accept(accept), .is_jreg(is_jreg),
    .is_jump(is_jump), .br_taken(br_taken), .sel(sel)
  );

  always_comb begin
    unique case (sel)
      SEL_EXC: pc_d = AW'(EXC_VECTOR);
      SEL_REG: pc_d = rs_val;
      SEL_JMP: pc_d = jmp_tgt;
      SEL_BR:  pc_d = br_tgt;
      default: pc_d = seq_tgt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= AW'(RESET_PC);
    else if (update) pc_q <= pc_d;
  end

  assign ret_addr  = seq_tgt;
  assign ret_valid = accept && is_call;

  // R8: stalled cycles leave the counter alone
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(pc_q));

  // R9: nothing offered, nothing changes
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !instr_valid && !exc_req) |=> $stable(pc_q));

  // R6: exception redirect wins whenever not stalled
  p_exc_vector_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && exc_req) |=> (pc_q == AW'(EXC_VECTOR)));

  // R5: register jump takes the full source value
  p_reg_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall && !exc_req && is_jreg) |=> (pc_q == $past(rs_val)));

  // R2: plain accepted instruction advances one word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !stall && !exc_req && !is_jreg && !is_jump && !br_taken)
      |=> (pc_q == $past(pc_q) + AW'(4)));

  // R10: no return strobe without an accepted instruction
  p_ret_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |-> (instr_valid && !stall && is_call));
endmodule

// File: tb/test_npc_unit.sv
module test_npc_unit;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] EXC_PC = 32'h0000_0020;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0, instr_valid = 1'b0;
  logic        instr_ready;
  logic [31:0] instr = '0;
  logic        br_taken = 1'b0, is_jump = 1'b0, is_jreg = 1'b0, is_call = 1'b0;
  logic [31:0] rs_val = '0;
  logic        exc_req = 1'b0;
  logic [31:0] pc_q;
  logic [5:0]  opcode;
  logic [31:0] ret_addr;
  logic        ret_valid;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] model_pc;

  typedef struct { logic [31:0] pc; string req; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  npc_unit i_npc_unit (
    .clk(clk), .rst_n(rst_n), .stall(stall), .instr_valid(instr_valid),
    .instr_ready(instr_ready), .instr(instr), .br_taken(br_taken),
    .is_jump(is_jump), .is_jreg(is_jreg), .is_call(is_call), .rs_val(rs_val),
    .exc_req(exc_req), .pc_q(pc_q), .opcode(opcode), .ret_addr(ret_addr),
    .ret_valid(ret_valid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compares pc one edge after each driven item
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.req, pc_q, e.pc);
    end
  end

  function automatic logic [31:0] predict(input logic s, v, x, jr, j, b,
                                          input logic [31:0] w, r, pc);
    if (s || (!v && !x)) return pc;
    if (x)  return EXC_PC;
    if (jr) return r;
    if (j)  return {pc[31:28], w[31:6], 2'b00};
    if (b)  return pc + 32'd4 + {{16{w[21]}}, w[21:6]};
    return pc + 32'd4;
  endfunction

  // driver: applies one cycle of stimulus and queues the expected pc
  task automatic step(input logic s, v, x, jr, j, b, c,
                      input logic [31:0] w, r, input string req);
    exp_t e;
    @(negedge clk);
    stall = s; instr_valid = v; exc_req = x; is_jreg = jr; is_jump = j;
    br_taken = b; is_call = c; instr = w; rs_val = r;
    #0.5;
    check("R8 ready", {31'd0, instr_ready}, {31'd0, !s});
    check("R11 opcode", {26'd0, opcode}, {26'd0, w[5:0]});
    check("R10 ret_addr", ret_addr, model_pc + 32'd4);
    check("R10 ret_valid", {31'd0, ret_valid}, {31'd0, (c && v && !s)});
    e.pc  = predict(s, v, x, jr, j, b, w, r, model_pc);
    e.req = req;
    model_pc = e.pc;
    exp_q.push_back(e);
  endtask

  initial begin
    #20000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", pc_q, RST_PC);
    rst_n = 1'b1;
    model_pc = RST_PC;
    @(negedge clk);
    check("R1 after release", pc_q, RST_PC);
    // R2 sequential, opcode 0x15
    step(0,1,0,0,0,0,0, 32'h0000_0015, 0, "R2 seq");
    step(0,1,0,0,0,0,0, 32'hFFFF_FFFF, 0, "R2 seq all ones word");
    // R3 branch: not taken, positive, negative offsets
    step(0,1,0,0,0,0,0, {10'd0, 16'h0040, 6'h06}, 0, "R2 branch not taken");
    step(0,1,0,0,0,1,0, {10'd0, 16'h0040, 6'h06}, 0, "R3 branch +0x40");
    step(0,1,0,0,0,1,0, {10'd0, 16'hFFF0, 6'h06}, 0, "R3 branch -0x10");
    step(0,1,0,0,0,1,0, {10'h3FF, 16'h8000, 6'h06}, 0, "R3 branch min offset");
    // R5 register jump with unaligned value, then R4 with high pc bits
    step(0,1,0,1,0,0,1, 32'h0000_0031, 32'hA000_0103, "R5 reg jump");
    step(0,1,0,0,1,0,1, {26'h123_4567, 6'h00}, 0, "R4 jump keeps top bits");
    step(0,1,0,0,1,0,0, {26'h3FF_FFFF, 6'h01}, 0, "R4 jump max word");
    // R9 idle, R8 stall with exception pending
    step(0,0,0,0,0,0,1, 32'h0, 0, "R9 idle hold");
    step(1,1,1,1,1,1,1, 32'h0, 32'h5555_5554, "R8 stall hold");
    step(1,0,1,0,0,0,0, 32'h0, 0, "R8 stall ignores exception");
    // R6 exception without valid instruction
    step(0,0,1,0,0,0,0, 32'h0, 0, "R6 exception no instr");
    // R7 priority combos
    step(0,1,1,1,1,1,0, 32'h0, 32'h0000_4000, "R7 exc over all");
    step(0,1,0,1,1,1,0, {26'h000_0100, 6'h00}, 32'h0000_4000, "R7 reg over jump");
    step(0,1,0,0,1,1,0, {26'h000_0200, 6'h00}, 0, "R7 jump over branch");
    step(0,1,0,0,0,1,1, {10'd0, 16'h0100, 6'h00}, 0, "R7 branch over seq");
    step(0,1,0,0,0,0,0, 32'h0, 0, "R2 seq after branch");
    @(negedge clk);
    instr_valid = 1'b0; exc_req = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 final hold", pc_q, model_pc);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule